// File: doc/BRIEF.md
# Snooze Power-Down Sequencer

This block steps a synchronous memory front end into and out of a data-retaining sleep state. An asynchronous, active-high request pin passes through a flop synchronizer. It then drives a four-state sequencer with the states run, entry, sleep and wake. During entry the front end still samples its inputs for a fixed number of cycles. Once sleep is reached, the input gate closes and the data outputs are forced undriven. A low-power status flag follows a fixed number of cycles later.

When the request pin falls, the sequencer opens a recovery window of fixed length before normal operation returns. In that window the input gate is open, but only idle, deselect or read commands are legal. The block watches the command type presented each cycle and raises a one-cycle violation pulse for illegal commands. These are a read or a write issued while entry is under way, and a write issued during recovery. If the pin rises again during recovery, the sequencer goes straight back into entry.

Top module: `snz_seq`

## Requirements
- R1: A change on `snooze_pin` reaches the sequencer through a two-flop synchronizer. With the pin raised before rising edge k, no output changes before edge k+2, and the sequencer enters the entry state at edge k+2.
- R2: The entry state lasts exactly ENTER_CYC cycles (default 2). During entry, `in_en` stays 1 and `out_off` stays 0.
- R3: After entry, the sequencer holds the sleep state until the synchronized pin is low. In sleep, `in_en` is 0 and `out_off` is 1.
- R4: `asleep` is 0 for the first LP_CYC cycles of sleep (default 2) and is 1 from the edge that ends them until sleep is left.
- R5: The sleep state is left at the second edge after the first edge that samples the pin low. The recovery state then lasts WAKE_CYC cycles (default 2) with `in_en`=1, `out_off`=0 and `asleep`=0, and is followed by the run state.
- R6: Command encoding on `cmd`: 2'b00 idle, 2'b01 deselect, 2'b10 read, 2'b11 write. A read or a write sampled while in the entry state sets `viol` to 1 for the following cycle only.
- R7: A write sampled in the recovery state sets `viol` for one cycle. A read, deselect or idle command sampled in recovery leaves `viol` at 0.
- R8: Commands sampled in the run or sleep state never set `viol`.
- R9: While `rst_n` is 0 at a rising edge, the block returns to run with `in_en`=1, `out_off`=0, `asleep`=0 and `viol`=0.
- R10: If the synchronized pin is high in the recovery state, the sequencer returns to the entry state at the next edge and goes back to sleep from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snooze_pin | input | 1 | Asynchronous active-high sleep request |
| cmd | input | 2 | Command type presented this cycle (idle, deselect, read, write) |
| in_en | output | 1 | 1 while synchronous inputs may be sampled |
| out_off | output | 1 | 1 while data outputs must be undriven |
| asleep | output | 1 | Low-power status reached |
| viol | output | 1 | One-cycle pulse for an illegal command during entry or recovery |

## Verification
The sequencer is driven through two full sleep cycles with different commands placed in each phase. Reads and writes issued in entry, recovery, run and sleep show whether the violation rule follows the phase or the command type. A write on the edge where entry begins, and on the first edge after recovery ends, pins down the exact window boundaries. A one-cycle low glitch on the pin during sleep exercises the wake-to-entry path. A reset issued while asleep checks the return to the idle state.

// File: rtl/snz_pkg.sv
// Package: shared types for the snooze sequencer.
// Assumes: command codes are fixed by the front end that decodes them.
package snz_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } snz_state_e;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_DESEL = 2'b01,
        CMD_READ  = 2'b10,
        CMD_WRITE = 2'b11
    } snz_cmd_e;
endpackage

// File: rtl/snz_sync.sv
// Module: multi-stage synchronizer for the asynchronous snooze request.
// Assumes: STAGES >= 2; reset clears every stage to the awake value.
module snz_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // One synchronizer flop; stage 0 takes the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[g] <= 1'b0;
                else if (g == 0)
                    chain[g] <= async_in;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> $past(chain[STAGES-2])); // R1
endmodule

// File: rtl/snz_fsm.sv
// Module: run/entry/sleep/wake sequencer with one shared cycle counter.
// Assumes: sync_req is already synchronous; all window lengths are >= 1.
module snz_fsm
    import snz_pkg::*;
#(
    parameter int ENTER_CYC = 2,
    parameter int LP_CYC    = 2,
    parameter int WAKE_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_req,
    output snz_state_e state_o,
    output logic       lp_reached
);
    localparam int MAX_A = (ENTER_CYC > LP_CYC) ? ENTER_CYC : LP_CYC;
    localparam int MAXC  = (MAX_A > WAKE_CYC) ? MAX_A : WAKE_CYC;
    localparam int CW    = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ENTER_LAST = CW'(ENTER_CYC - 1);
    localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] LP_DONE    = CW'(LP_CYC);

    snz_state_e    state_q;
    logic [CW-1:0] cnt_q;

    // State and window counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (sync_req) begin
                        state_q <= ST_ENTER;
                        cnt_q   <= '0;
                    end
                end
                ST_ENTER: begin
                    if (cnt_q == ENTER_LAST) begin
                        state_q <= ST_SLEEP;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (!sync_req) begin
                        state_q <= ST_WAKE;
                        cnt_q   <= '0;
                    end else if (cnt_q != LP_DONE) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (sync_req) begin
                        state_q <= ST_ENTER;
                        cnt_q   <= '0;
                    end else if (cnt_q == WAKE_LAST) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_RUN;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Status decode from the registered state.
    always_comb begin
        state_o    = state_q;
        lp_reached = (state_q == ST_SLEEP) && (cnt_q == LP_DONE);
    end

    AST_ENTER_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER && $past(state_q) != ST_ENTER) |-> $past(sync_req)); // R1
    AST_SLEEP_AFTER_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP) |-> $past(state_q) == ST_ENTER); // R2
    AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && $past(state_q) != ST_WAKE) |-> $past(state_q) == ST_SLEEP); // R5
    AST_LP_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_reached) |-> $past(state_q) == ST_SLEEP); // R4
endmodule

// File: rtl/snz_viol.sv
// Module: flags commands that are illegal for the current sequencer phase.
// Assumes: cmd is valid on every edge; the flag is a registered one-cycle pulse.
module snz_viol
    import snz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  snz_state_e state_i,
    input  logic [1:0] cmd,
    output logic       viol
);
    logic is_rw;
    logic is_wr;
    logic bad;

    // Classify the command and the phase it lands in.
    always_comb begin
        is_rw = (cmd == CMD_READ) || (cmd == CMD_WRITE);
        is_wr = (cmd == CMD_WRITE);
        bad   = ((state_i == ST_ENTER) && is_rw) ||
                ((state_i == ST_WAKE)  && is_wr);
    end

    // Register the violation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            viol <= 1'b0;
        else
            viol <= bad;
    end

    AST_VIOL_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(is_rw)); // R6
    AST_VIOL_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> ($past(state_i) == ST_ENTER || $past(state_i) == ST_WAKE)); // R8
    AST_WAKE_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_WAKE && !is_wr) |=> !viol); // R7
endmodule

// File: rtl/snz_seq.sv
// Module: top of the snooze power-down sequencer.
// Assumes: snooze_pin is asynchronous; rst_n is synchronous to clk.
module snz_seq
    import snz_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTER_CYC   = 2,
    parameter int LP_CYC      = 2,
    parameter int WAKE_CYC    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snooze_pin,
    input  logic [1:0] cmd,
    output logic       in_en,
    output logic       out_off,
    output logic       asleep,
    output logic       viol
);
    logic       req_s;
    snz_state_e state;
    logic       lp;

    snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (snooze_pin),
        .sync_out (req_s)
    );

    snz_fsm #(
        .ENTER_CYC (ENTER_CYC),
        .LP_CYC    (LP_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_req   (req_s),
        .state_o    (state),
        .lp_reached (lp)
    );

    snz_viol u_viol (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state),
        .cmd     (cmd),
        .viol    (viol)
    );

    // Drive gate and status outputs from the sequencer phase.
    always_comb begin
        in_en   = (state != ST_SLEEP);
        out_off = (state == ST_SLEEP);
        asleep  = lp;
    end

    AST_ASLEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> $past(out_off)); // R4
    AST_GATE_OPENS_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_off) |-> (in_en && !asleep)); // R5
endmodule

// File: tb/tb_snz_seq.sv
module tb_snz_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 26;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       snooze_pin;
    logic [1:0] cmd;
    logic       in_en, out_off, asleep, viol;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    snz_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .snooze_pin (snooze_pin),
        .cmd        (cmd),
        .in_en      (in_en),
        .out_off    (out_off),
        .asleep     (asleep),
        .viol       (viol)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: [10] pin, [9:8] cmd, [7:4] expected {in_en,out_off,asleep,viol}, [3:0] requirement
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b0, 2'b11, 4'b1000, 4'd8},  // 0  write in run, no flag R8
        {1'b1, 2'b10, 4'b1000, 4'd1},  // 1  pin high, first sync stage R1
        {1'b1, 2'b00, 4'b1000, 4'd1},  // 2  second stage R1
        {1'b1, 2'b00, 4'b1000, 4'd2},  // 3  enter starts R2
        {1'b1, 2'b10, 4'b1001, 4'd6},  // 4  read in entry flagged R6
        {1'b1, 2'b00, 4'b0100, 4'd3},  // 5  sleep, pulse ends R3
        {1'b1, 2'b11, 4'b0100, 4'd8},  // 6  write in sleep ignored R8
        {1'b1, 2'b00, 4'b0110, 4'd4},  // 7  low-power reached R4
        {1'b0, 2'b00, 4'b0110, 4'd3},  // 8  still asleep R3
        {1'b0, 2'b00, 4'b0110, 4'd3},  // 9
        {1'b0, 2'b00, 4'b1000, 4'd5},  // 10 recovery R5
        {1'b0, 2'b11, 4'b1001, 4'd7},  // 11 write in recovery flagged R7
        {1'b0, 2'b10, 4'b1000, 4'd7},  // 12 read in recovery legal R7
        {1'b0, 2'b11, 4'b1000, 4'd5},  // 13 run again after two cycles R5
        {1'b1, 2'b00, 4'b1000, 4'd1},  // 14
        {1'b1, 2'b00, 4'b1000, 4'd1},  // 15
        {1'b1, 2'b11, 4'b1000, 4'd6},  // 16 write on entry edge, still run R6
        {1'b1, 2'b11, 4'b1001, 4'd6},  // 17 write in entry flagged R6
        {1'b1, 2'b00, 4'b0100, 4'd2},  // 18 sleep after two entry cycles R2
        {1'b1, 2'b00, 4'b0100, 4'd4},  // 19 not yet low power R4
        {1'b0, 2'b00, 4'b0110, 4'd4},  // 20 low power R4
        {1'b1, 2'b00, 4'b0110, 4'd3},  // 21 glitch low still in pipe R3
        {1'b1, 2'b00, 4'b1000, 4'd5},  // 22 recovery R5
        {1'b1, 2'b11, 4'b1001, 4'd10}, // 23 pin back: to entry, write flagged R10
        {1'b1, 2'b10, 4'b1001, 4'd10}, // 24 read in re-entry flagged R10
        {1'b1, 2'b00, 4'b0100, 4'd10}  // 25 back to sleep R10
    };

    task automatic check(input logic [3:0] got, input logic [3:0] exp, input int req);
        tests_run++;
        if (got !== exp) begin
            tests_failed++;
            $display("FAIL R%0d: {in_en,out_off,asleep,viol} actual %b expected %b", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        snooze_pin = 1'b0;
        cmd = 2'b00;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check({in_en, out_off, asleep, viol}, 4'b1000, 9); // R9 reset state
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            snooze_pin = VEC[i][10];
            cmd = VEC[i][9:8];
            @(posedge clk);
            #(CLK_PERIOD/4);
            check({in_en, out_off, asleep, viol}, VEC[i][7:4], int'(VEC[i][3:0]));
        end

        // R9: reset while asleep returns to run
        @(negedge clk); cmd = 2'b00;
        @(posedge clk); #(CLK_PERIOD/4);
        @(negedge clk); snooze_pin = 1'b0; rst_n = 1'b0;
        @(posedge clk); #(CLK_PERIOD/4);
        check({in_en, out_off, asleep, viol}, 4'b1000, 9); // R9
        @(negedge clk); rst_n = 1'b1;

        // R8: deselect in entry is legal; R6 read/write only
        @(negedge clk); snooze_pin = 1'b1;
        repeat (2) begin @(negedge clk); end
        @(negedge clk); cmd = 2'b01; // entry state during this cycle
        @(posedge clk); #(CLK_PERIOD/4);
        check({in_en, out_off, asleep, viol}, 4'b1000, 6); // R6 deselect not flagged
        @(negedge clk); cmd = 2'b00;
        @(posedge clk); #(CLK_PERIOD/4);
        check({in_en, out_off, asleep, viol}, 4'b0100, 3); // R3
        finish_run();
    end

    initial begin
        repeat (2000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule